// File: doc/BRIEF.md
# Physical Register Readiness Scoreboard with Wakeup Slots

This block tracks, for every physical register of the machine (integer and floating-point files counted together), whether its value has been produced. A register loses its ready state when an instruction is allocated to write it, and regains it when that producer completes. Each completion broadcasts the destination tag to a small table of waiting instruction slots. A slot holds two source tags with a ready flag for each. It raises its issue-request line once both sources are ready.

An instruction can be in flight to the queue while the producer of one of its sources completes. The block handles this by checking the scoreboard when the instruction is written into a slot. A completion broadcast in the same cycle as the write also counts. Tags at or above the physical register count name registers that are not tracked. Such a source never waits, and such a destination never touches the scoreboard. The caller picks the slot to write and removes slots with a kill mask. The mask serves both for squash and for release after issue.

Top module: `preg_wake_sb`

## Requirements
- R1: The output `sb_rdy` has one bit per tracked physical register. Bit i holds the ready state of register i, for i from 0 to NUM_PREGS-1.
- R2: After reset every `sb_rdy` bit is 0 and every `req` bit is 0.
- R3: An allocation with a tracked destination clears that register's `sb_rdy` bit at the next clock edge.
- R4: A completion with a tracked destination sets that register's `sb_rdy` bit at the next clock edge. At the same edge it marks ready every source in an occupied slot whose tag equals the broadcast tag.
- R5: On insertion, a source whose input ready flag is 0 is still captured as ready when the scoreboard bit of its tag is 1 in that cycle.
- R6: A tag of NUM_PREGS or above is untracked. As a source it is captured as ready. As an allocation or completion destination it leaves `sb_rdy` unchanged.
- R7: `req[i]` is 1 exactly when slot i is occupied and both of its sources are ready. Once up, it stays up until the slot is killed or overwritten.
- R8: Setting `kill_mask[i]` empties slot i at the next edge. A later completion of one of its pending tags does not raise `req[i]`.
- R9: When a completion broadcast and an insertion whose source carries the same tag fall in the same cycle, that source is captured as ready.
- R10: When an allocation and a completion name the same tracked register in one cycle, the register ends up ready.
- R11: An insertion into slot i takes precedence over `kill_mask[i]` in the same cycle. An insertion into an occupied slot replaces its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_vld | input | 1 | An instruction is allocated as producer of `alloc_dst` |
| alloc_dst | input | TAG_W | Destination tag being allocated |
| cmpl_vld | input | 1 | A producer completes; broadcast `cmpl_dst` |
| cmpl_dst | input | TAG_W | Destination tag of the completing instruction |
| ins_vld | input | 1 | Write an instruction into slot `ins_slot` |
| ins_slot | input | SLOT_W | Slot to write |
| ins_src0 | input | TAG_W | First source tag |
| ins_src0_rdy | input | 1 | First source already known ready |
| ins_src1 | input | TAG_W | Second source tag |
| ins_src1_rdy | input | 1 | Second source already known ready |
| kill_mask | input | NUM_SLOTS | Slots to empty (squash or release) |
| req | output | NUM_SLOTS | Issue request per slot |
| sb_rdy | output | NUM_PREGS | Scoreboard ready bits |

## Verification
Every result is due one clock edge after its stimulus. Scoreboard bits, captured source state and slot occupancy are all registered. `req` is decoded from that registered state without further delay. The bench changes inputs one nanosecond after a rising edge. It then samples `sb_rdy` and `req` one nanosecond after the following edge, and compares them with a bench model advanced by exactly one step per edge. Directed sequences place completions in the cycle before an insertion and in the same cycle as one. They also place kills before a late wakeup. Each directed check is made at the first sample after its stimulus.

// File: rtl/preg_wake_pkg.sv
package preg_wake_pkg;

  // A tag names a tracked register only when it lies below the register count.
  function automatic bit tag_tracked(int unsigned tag, int unsigned npregs);
    return tag < npregs;
  endfunction

  // Readiness of a source at the moment it is written into a slot:
  // caller flag, untracked tag, scoreboard lookup or same-cycle broadcast.
  function automatic bit src_ready_at_insert(bit flag, int unsigned tag,
                                             int unsigned npregs, bit lookup,
                                             bit bcast_vld, int unsigned bcast_tag);
    return flag || !tag_tracked(tag, npregs) || lookup ||
           (bcast_vld && (bcast_tag == tag));
  endfunction

endpackage

// File: rtl/preg_sb_table.sv
module preg_sb_table #(
  parameter int NUM_PREGS = 64,
  parameter int TAG_W     = 7,
  localparam int IDX_W    = $clog2(NUM_PREGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_vld,
  input  logic [TAG_W-1:0]     clr_tag,
  input  logic                 set_vld,
  input  logic [TAG_W-1:0]     set_tag,
  input  logic [TAG_W-1:0]     rd_tag0,
  input  logic [TAG_W-1:0]     rd_tag1,
  output logic                 rd_rdy0,
  output logic                 rd_rdy1,
  output logic [NUM_PREGS-1:0] rdy_vec
);
  import preg_wake_pkg::*;

  logic [NUM_PREGS-1:0] rdy_q;
  logic [NUM_PREGS-1:0] set_vec;
  logic [NUM_PREGS-1:0] clr_vec;

  // Per-register decode; an untracked tag matches no index.
  for (genvar g = 0; g < NUM_PREGS; g++) begin : g_dec
    assign set_vec[g] = set_vld && (set_tag == TAG_W'(g));
    assign clr_vec[g] = clr_vld && (clr_tag == TAG_W'(g));
  end

  // Set wins over clear when both name the same register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= '0;
    else        rdy_q <= (rdy_q & ~clr_vec) | set_vec;
  end

  function automatic logic lookup(logic [TAG_W-1:0] tag);
    if (tag_tracked(int'(tag), NUM_PREGS)) return rdy_q[tag[IDX_W-1:0]];
    return 1'b0;
  endfunction

  assign rd_rdy0 = lookup(rd_tag0);
  assign rd_rdy1 = lookup(rd_tag1);
  assign rdy_vec = rdy_q;

endmodule

// File: rtl/preg_wait_slot.sv
module preg_wait_slot #(
  parameter int TAG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag0,
  input  logic             wr_rdy0,
  input  logic [TAG_W-1:0] wr_tag1,
  input  logic             wr_rdy1,
  input  logic             kill,
  input  logic             wake_vld,
  input  logic [TAG_W-1:0] wake_tag,
  output logic             occupied,
  output logic             req
);
  logic             vld_q;
  logic [TAG_W-1:0] tag0_q, tag1_q;
  logic             rdy0_q, rdy1_q;
  logic             wake_hit0, wake_hit1;

  assign wake_hit0 = vld_q && wake_vld && (wake_tag == tag0_q);
  assign wake_hit1 = vld_q && wake_vld && (wake_tag == tag1_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      tag0_q <= '0;
      tag1_q <= '0;
      rdy0_q <= 1'b0;
      rdy1_q <= 1'b0;
    end else if (wr_en) begin
      vld_q  <= 1'b1;
      tag0_q <= wr_tag0;
      tag1_q <= wr_tag1;
      rdy0_q <= wr_rdy0;
      rdy1_q <= wr_rdy1;
    end else if (kill) begin
      vld_q  <= 1'b0;
      rdy0_q <= 1'b0;
      rdy1_q <= 1'b0;
    end else begin
      if (wake_hit0) rdy0_q <= 1'b1;
      if (wake_hit1) rdy1_q <= 1'b1;
    end
  end

  assign occupied = vld_q;
  assign req      = vld_q && rdy0_q && rdy1_q;

endmodule

// File: rtl/preg_wake_sb.sv
module preg_wake_sb #(
  parameter int NUM_PREGS = 64,
  parameter int NUM_SLOTS = 8,
  parameter int TAG_W     = 7,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_vld,
  input  logic [TAG_W-1:0]     alloc_dst,
  input  logic                 cmpl_vld,
  input  logic [TAG_W-1:0]     cmpl_dst,
  input  logic                 ins_vld,
  input  logic [SLOT_W-1:0]    ins_slot,
  input  logic [TAG_W-1:0]     ins_src0,
  input  logic                 ins_src0_rdy,
  input  logic [TAG_W-1:0]     ins_src1,
  input  logic                 ins_src1_rdy,
  input  logic [NUM_SLOTS-1:0] kill_mask,
  output logic [NUM_SLOTS-1:0] req,
  output logic [NUM_PREGS-1:0] sb_rdy
);
  import preg_wake_pkg::*;

  logic                 look_rdy0, look_rdy1;
  logic                 cap_rdy0, cap_rdy1;
  logic [NUM_SLOTS-1:0] ins_sel;
  logic [NUM_SLOTS-1:0] slot_occ;

  preg_sb_table #(.NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_vld (alloc_vld),
    .clr_tag (alloc_dst),
    .set_vld (cmpl_vld),
    .set_tag (cmpl_dst),
    .rd_tag0 (ins_src0),
    .rd_tag1 (ins_src1),
    .rd_rdy0 (look_rdy0),
    .rd_rdy1 (look_rdy1),
    .rdy_vec (sb_rdy)
  );

  // Insert-time capture: scoreboard lookup plus same-cycle broadcast bypass.
  assign cap_rdy0 = src_ready_at_insert(ins_src0_rdy, int'(ins_src0), NUM_PREGS,
                                        look_rdy0, cmpl_vld, int'(cmpl_dst));
  assign cap_rdy1 = src_ready_at_insert(ins_src1_rdy, int'(ins_src1), NUM_PREGS,
                                        look_rdy1, cmpl_vld, int'(cmpl_dst));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign ins_sel[s] = ins_vld && (ins_slot == SLOT_W'(s));

    preg_wait_slot #(.TAG_W(TAG_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ins_sel[s]),
      .wr_tag0  (ins_src0),
      .wr_rdy0  (cap_rdy0),
      .wr_tag1  (ins_src1),
      .wr_rdy1  (cap_rdy1),
      .kill     (kill_mask[s]),
      .wake_vld (cmpl_vld),
      .wake_tag (cmpl_dst),
      .occupied (slot_occ[s]),
      .req      (req[s])
    );
  end

endmodule

// File: rtl/preg_wake_sb_chk.sv
module preg_wake_sb_chk #(
  parameter int NUM_PREGS = 64,
  parameter int NUM_SLOTS = 8,
  parameter int TAG_W     = 7,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int IDX_W    = $clog2(NUM_PREGS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 alloc_vld,
  input logic [TAG_W-1:0]     alloc_dst,
  input logic                 cmpl_vld,
  input logic [TAG_W-1:0]     cmpl_dst,
  input logic                 ins_vld,
  input logic [SLOT_W-1:0]    ins_slot,
  input logic                 ins_src0_rdy,
  input logic                 ins_src1_rdy,
  input logic [NUM_SLOTS-1:0] kill_mask,
  input logic [NUM_SLOTS-1:0] ins_sel,
  input logic [NUM_SLOTS-1:0] req,
  input logic [NUM_PREGS-1:0] sb_rdy
);
  logic alloc_trk, cmpl_trk;
  assign alloc_trk = alloc_vld && (int'(alloc_dst) < NUM_PREGS);
  assign cmpl_trk  = cmpl_vld  && (int'(cmpl_dst)  < NUM_PREGS);

  AST_CMPL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_trk |=> sb_rdy[$past(cmpl_dst[IDX_W-1:0])]); // R4

  AST_ALLOC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_trk && !(cmpl_vld && cmpl_dst == alloc_dst)
    |=> !sb_rdy[$past(alloc_dst[IDX_W-1:0])]); // R3

  AST_UNTRACKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_trk && !cmpl_trk |=> $stable(sb_rdy)); // R6

  AST_READY_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    ins_vld && ins_src0_rdy && ins_src1_rdy |=> req[$past(ins_slot)]); // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req & ~(kill_mask | ins_sel)) != '0
    |=> (($past(req & ~(kill_mask | ins_sel)) & ~req) == '0)); // R7

  AST_KILL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_mask & ~ins_sel) != '0
    |=> ((req & $past(kill_mask & ~ins_sel)) == '0)); // R8

endmodule

bind preg_wake_sb preg_wake_sb_chk #(
  .NUM_PREGS(NUM_PREGS), .NUM_SLOTS(NUM_SLOTS), .TAG_W(TAG_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alloc_vld    (alloc_vld),
  .alloc_dst    (alloc_dst),
  .cmpl_vld     (cmpl_vld),
  .cmpl_dst     (cmpl_dst),
  .ins_vld      (ins_vld),
  .ins_slot     (ins_slot),
  .ins_src0_rdy (ins_src0_rdy),
  .ins_src1_rdy (ins_src1_rdy),
  .kill_mask    (kill_mask),
  .ins_sel      (ins_sel),
  .req          (req),
  .sb_rdy       (sb_rdy)
);

// File: tb/preg_wake_sb_bench.sv
`timescale 1ns/1ps
module preg_wake_sb_bench;
  localparam int NP = 64;
  localparam int NS = 8;
  localparam int TW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc_vld = 0, cmpl_vld = 0, ins_vld = 0;
  logic [TW-1:0] alloc_dst = 0, cmpl_dst = 0, ins_src0 = 0, ins_src1 = 0;
  logic [2:0]    ins_slot = 0;
  logic          ins_src0_rdy = 0, ins_src1_rdy = 0;
  logic [NS-1:0] kill_mask = 0;
  logic [NS-1:0] req;
  logic [NP-1:0] sb_rdy;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  preg_wake_sb u_preg_wake_sb (
    .clk(clk), .rst_n(rst_n),
    .alloc_vld(alloc_vld), .alloc_dst(alloc_dst),
    .cmpl_vld(cmpl_vld), .cmpl_dst(cmpl_dst),
    .ins_vld(ins_vld), .ins_slot(ins_slot),
    .ins_src0(ins_src0), .ins_src0_rdy(ins_src0_rdy),
    .ins_src1(ins_src1), .ins_src1_rdy(ins_src1_rdy),
    .kill_mask(kill_mask), .req(req), .sb_rdy(sb_rdy)
  );

  // Bench model, written from the requirements.
  bit [NP-1:0] m_sb;
  bit m_v[NS], m_r0[NS], m_r1[NS];
  int m_t0[NS], m_t1[NS];

  function automatic bit m_cap(bit flag, int t);
    if (flag || t >= NP) return 1'b1;
    if (m_sb[t]) return 1'b1;
    return cmpl_vld && (int'(cmpl_dst) == t);
  endfunction

  function automatic bit [NS-1:0] m_req();
    bit [NS-1:0] r;
    for (int i = 0; i < NS; i++) r[i] = m_v[i] && m_r0[i] && m_r1[i];
    return r;
  endfunction

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic clr_in();
    alloc_vld = 0; cmpl_vld = 0; ins_vld = 0;
    ins_src0_rdy = 0; ins_src1_rdy = 0; kill_mask = '0;
  endtask

  // One clock: model step from current inputs, edge, sample and compare.
  task automatic tick();
    bit [NP-1:0] n_sb;
    bit nv[NS], nr0[NS], nr1[NS];
    int nt0[NS], nt1[NS];
    n_sb = m_sb;
    if (alloc_vld && int'(alloc_dst) < NP) n_sb[alloc_dst[5:0]] = 1'b0;
    if (cmpl_vld && int'(cmpl_dst) < NP)   n_sb[cmpl_dst[5:0]]  = 1'b1;
    for (int i = 0; i < NS; i++) begin
      nv[i] = m_v[i]; nr0[i] = m_r0[i]; nr1[i] = m_r1[i];
      nt0[i] = m_t0[i]; nt1[i] = m_t1[i];
      if (ins_vld && int'(ins_slot) == i) begin
        nv[i] = 1; nt0[i] = int'(ins_src0); nt1[i] = int'(ins_src1);
        nr0[i] = m_cap(ins_src0_rdy, int'(ins_src0));
        nr1[i] = m_cap(ins_src1_rdy, int'(ins_src1));
      end else if (kill_mask[i]) begin
        nv[i] = 0; nr0[i] = 0; nr1[i] = 0;
      end else if (m_v[i] && cmpl_vld) begin
        if (m_t0[i] == int'(cmpl_dst)) nr0[i] = 1;
        if (m_t1[i] == int'(cmpl_dst)) nr1[i] = 1;
      end
    end
    @(posedge clk);
    #1;
    m_sb = n_sb;
    for (int i = 0; i < NS; i++) begin
      m_v[i] = nv[i]; m_r0[i] = nr0[i]; m_r1[i] = nr1[i];
      m_t0[i] = nt0[i]; m_t1[i] = nt1[i];
    end
    chk("R4 sb_rdy model", 64'(sb_rdy), 64'(m_sb));
    chk("R7 req model", 64'(req), 64'(m_req()));
  endtask

  task automatic put(int slot, int s0, bit f0, int s1, bit f1);
    ins_vld = 1; ins_slot = 3'(slot);
    ins_src0 = TW'(s0); ins_src0_rdy = f0;
    ins_src1 = TW'(s1); ins_src1_rdy = f1;
  endtask

  function automatic int rtag();
    if ($urandom % 8 == 0) return 64 + int'($urandom % 64);
    return int'($urandom % 20);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [NP-1:0] sb_before;
    void'($urandom(32'd1234));
    m_sb = '0;
    for (int i = 0; i < NS; i++) begin
      m_v[i] = 0; m_r0[i] = 0; m_r1[i] = 0; m_t0[i] = 0; m_t1[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R2 reset sb_rdy", 64'(sb_rdy), 64'h0);
    chk("R2 reset req", 64'(req), 64'h0);

    // R1: completing register 63 sets exactly bit 63
    cmpl_vld = 1; cmpl_dst = 7'd63; tick(); clr_in();
    chk("R1 bit position", 64'(sb_rdy), 64'h8000_0000_0000_0000);

    // R4: slot 0 waits on 20 and 21
    put(0, 20, 0, 21, 0); tick(); clr_in();
    chk("R7 pending no req", 64'(req), 64'h0);
    cmpl_vld = 1; cmpl_dst = 7'd20; tick(); clr_in();
    chk("R4 one source woken", 64'(req), 64'h0);
    cmpl_vld = 1; cmpl_dst = 7'd21; tick(); clr_in();
    chk("R4 both woken", 64'(req), 64'h01);

    // R5: source completed before insertion
    cmpl_vld = 1; cmpl_dst = 7'd5; tick(); clr_in();
    put(1, 5, 0, 0, 1); tick(); clr_in();
    chk("R5 insert lookup", 64'(req), 64'h03);

    // R9: broadcast in the insertion cycle
    put(2, 9, 0, 9, 0); cmpl_vld = 1; cmpl_dst = 7'd9; tick(); clr_in();
    chk("R9 same-cycle bypass", 64'(req), 64'h07);

    // R6: untracked tags
    sb_before = sb_rdy;
    put(3, 70, 0, 127, 0);
    cmpl_vld = 1; cmpl_dst = 7'd100; alloc_vld = 1; alloc_dst = 7'd90;
    tick(); clr_in();
    chk("R6 untracked source ready", 64'(req), 64'h0F);
    chk("R6 scoreboard untouched", 64'(sb_rdy), 64'(sb_before));

    // R8: killed waiter is not woken
    alloc_vld = 1; alloc_dst = 7'd12; tick(); clr_in();
    put(4, 12, 0, 0, 1); tick(); clr_in();
    kill_mask = 8'h10; tick(); clr_in();
    cmpl_vld = 1; cmpl_dst = 7'd12; tick(); clr_in();
    chk("R8 killed slot stays low", 64'(req), 64'h0F);
    chk("R4 reg 12 set", 64'(sb_rdy[12]), 64'h1);

    // R3: allocation clears, captured slot keeps request
    alloc_vld = 1; alloc_dst = 7'd20; tick(); clr_in();
    chk("R3 alloc clears", 64'(sb_rdy[20]), 64'h0);
    chk("R7 request held", 64'(req), 64'h0F);

    // R10: allocate and complete same register
    alloc_vld = 1; alloc_dst = 7'd30; cmpl_vld = 1; cmpl_dst = 7'd30; tick(); clr_in();
    chk("R10 set wins", 64'(sb_rdy[30]), 64'h1);

    // R11: insert beats kill; insert overwrites occupied slot
    put(4, 1, 1, 2, 1); kill_mask = 8'h10; tick(); clr_in();
    chk("R11 insert over kill", 64'(req), 64'h1F);
    put(0, 40, 0, 3, 1); tick(); clr_in();
    chk("R11 overwrite", 64'(req), 64'h1E);

    kill_mask = 8'hFF; tick(); clr_in();
    chk("R8 kill all", 64'(req), 64'h0);

    // Constrained random phase, checked every cycle against the model
    for (int c = 0; c < 3000; c++) begin
      alloc_vld = ($urandom % 4 == 0); alloc_dst = TW'(rtag());
      cmpl_vld  = ($urandom % 3 == 0); cmpl_dst  = TW'(rtag());
      if ($urandom % 2 == 0)
        put(int'($urandom % NS), rtag(), ($urandom % 4 == 0),
            rtag(), ($urandom % 4 == 0));
      else ins_vld = 0;
      kill_mask = ($urandom % 6 == 0) ? NS'(1 << ($urandom % NS)) : '0;
      tick();
    end
    clr_in();
    tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule